// File: doc/BRIEF.md
# CVSD Bit-Stream Decoder with Idle Injection

This block turns a serial continuously-variable-slope delta bit stream back into signed 16-bit samples. Each accepted bit goes into a short history register. A run detector looks at that history, a syllabic step filter widens the step while runs last and narrows it when they stop, and a leaky integrator adds or subtracts the step to give the next sample. The step, leak and run logic match the companion encoder exactly. With the same bits and the same run-length setting, the decoder's sample sequence is therefore identical to the encoder's local reconstruction.

Three plain control pins shape the behaviour. A run-length select picks three-bit or four-bit runs, and a change takes effect on the next accepted bit. An active-low idle pin replaces the received bits with an internally generated alternating pattern, which draws the output toward mid-scale. An active-low powersave pin clears all state, holds the sample at zero and refuses input.

Bits arrive on a valid/ready stream. Ready is high whenever the block is powered, so the sender sees back-pressure only during powersave. Samples leave on a valid-only stream that cannot be back-pressured: the consumer must take each sample in the cycle its valid pulse is high.

Top module: `cvsd_decoder`

## Requirements
- R1: After reset, and one clock edge after `pwr_n` is sampled low, `out_sample` is 0 and `out_valid` is 0. While `pwr_n` stays low the integrator is cleared to 0, the step is set to its minimum (16), the history is cleared to all zeros and the idle phase is set to 1.
- R2: `in_ready` equals `pwr_n`. A bit is accepted only on a clock edge where `in_valid` and `in_ready` are both 1. While `pwr_n` is 0, bits presented on `in_bit` have no effect on state.
- R3: `out_valid` is 1 for exactly the one cycle after each accepting edge, and `out_sample` then carries the updated sample. At any other time while powered, `out_sample` holds its value.
- R4: The effective bit is shifted into a 4-bit history (newest in bit 0). A run exists when the newest 3 bits are all equal (`algo3` = 1) or the newest 4 bits are all equal (`algo3` = 0).
- R5: On each accepted bit the step becomes min(step+256, 4096) if there is a run, otherwise max(step − (step>>5), 16).
- R6: On each accepted bit the integrator becomes integ − (integ>>>6) + step' if the effective bit is 1, or integ − (integ>>>6) − step' if it is 0. Here step' is the step just computed in R5. The result is saturated to the range [−32768, 32767].
- R7: While `idle_n` is 0, the effective bit is the idle phase, which toggles after every accepted bit. `in_bit` is ignored. After a long idle period the sample settles within ±32 of zero.
- R8: A change of `algo3` applies to the next accepted bit, with no flush of history or step.
- R9: A stream with no runs of three (repeated 110) gives a peak sample magnitude less than half the peak produced by a stream with 30% run density.
- R10: After leaving powersave, decoding restarts exactly as it does after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low powersave: clears state, holds output at 0 |
| idle_n | input | 1 | Active-low force idle: inject alternating bits |
| algo3 | input | 1 | Run length select: 1 = three-bit runs, 0 = four-bit runs |
| in_valid | input | 1 | Received bit is present |
| in_ready | output | 1 | Decoder can accept a bit (equals `pwr_n`) |
| in_bit | input | 1 | Received delta bit |
| out_valid | output | 1 | One-cycle pulse: new sample available |
| out_sample | output | 16 | Reconstructed signed sample |

## Verification
Each accepted bit changes the history, step and integrator registers on the accepting edge. `out_valid` and the new `out_sample` are therefore due in the cycle that follows that edge. A powersave request clears the output one edge after `pwr_n` is first seen low. The bench drives inputs just after a rising edge and samples on the next falling edge. For each bit it queues the value the requirements predict, pops one entry at every valid pulse, and in cycles without a pulse checks that the last value is held. Hand-computed samples for three-bit versus four-bit runs, saturation at both rails, settling under idle, and run-density peaks are checked at the same falling-edge point.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;

  // run-length selection carried on the algo3 pin
  typedef enum logic {
    MODE_LONG  = 1'b0,
    MODE_SHORT = 1'b1
  } run_mode_e;

endpackage

// File: rtl/cvsd_bit_select.sv
module cvsd_bit_select
  import cvsd_pkg::*;
#(
  parameter int RUN_SHORT = 3,
  parameter int RUN_LONG  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic accept,
  input  logic in_bit,
  input  logic idle_n,
  input  logic algo3,
  output logic eff_bit,
  output logic run
);

  logic [RUN_LONG-1:0] hist_q, hist_d;
  logic                phase_q;
  run_mode_e           mode;

  assign mode = run_mode_e'(algo3);

  always_comb begin
    eff_bit = idle_n ? in_bit : phase_q;
    hist_d  = {hist_q[RUN_LONG-2:0], eff_bit};
    run     = 1'b1;
    for (int i = 1; i < RUN_LONG; i++) begin
      if (((mode == MODE_SHORT) ? (i < RUN_SHORT) : 1'b1) && (hist_d[i] != hist_d[0]))
        run = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      phase_q <= 1'b1;
    end else if (clr) begin
      hist_q  <= '0;
      phase_q <= 1'b1;
    end else if (accept) begin
      hist_q <= hist_d;
      if (!idle_n) phase_q <= ~phase_q;
    end
  end

endmodule

// File: rtl/cvsd_step_adapt.sv
module cvsd_step_adapt #(
  parameter int SW       = 13,
  parameter int STEP_MIN = 16,
  parameter int STEP_MAX = 4096,
  parameter int STEP_INC = 256,
  parameter int DECAY_SH = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          accept,
  input  logic          run,
  output logic [SW-1:0] step_q,
  output logic [SW-1:0] step_d
);

  logic [SW:0]   grow;
  logic [SW-1:0] shrink;

  always_comb begin
    grow   = {1'b0, step_q} + (SW+1)'(STEP_INC);
    shrink = step_q - (step_q >> DECAY_SH);
    if (run) begin
      step_d = (grow > (SW+1)'(STEP_MAX)) ? SW'(STEP_MAX) : grow[SW-1:0];
    end else begin
      step_d = (shrink < SW'(STEP_MIN)) ? SW'(STEP_MIN) : shrink;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_q <= SW'(STEP_MIN);
    else if (clr)    step_q <= SW'(STEP_MIN);
    else if (accept) step_q <= step_d;
  end

endmodule

// File: rtl/cvsd_leaky_integ.sv
module cvsd_leaky_integ #(
  parameter int W       = 16,
  parameter int SW      = 13,
  parameter int LEAK_SH = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                accept,
  input  logic                bit_in,
  input  logic [SW-1:0]       step,
  output logic signed [W-1:0] integ_q
);

  localparam int AW = W + 2;
  localparam logic signed [AW-1:0] POS_LIM = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [AW-1:0] NEG_LIM = {3'b111, {(W-1){1'b0}}};

  logic signed [AW-1:0] ext, leak, delta, sum;
  logic signed [W-1:0]  integ_d;

  always_comb begin
    ext   = {{2{integ_q[W-1]}}, integ_q};
    leak  = ext >>> LEAK_SH;
    delta = signed'({{(AW-SW){1'b0}}, step});
    if (!bit_in) delta = -delta;
    sum = ext - leak + delta;
    if (sum > POS_LIM)      integ_d = POS_LIM[W-1:0];
    else if (sum < NEG_LIM) integ_d = NEG_LIM[W-1:0];
    else                    integ_d = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      integ_q <= '0;
    else if (clr)    integ_q <= '0;
    else if (accept) integ_q <= integ_d;
  end

endmodule

// File: rtl/cvsd_decoder.sv
module cvsd_decoder #(
  parameter int W         = 16,
  parameter int STEP_MIN  = 16,
  parameter int STEP_MAX  = 4096,
  parameter int STEP_INC  = 256,
  parameter int DECAY_SH  = 5,
  parameter int LEAK_SH   = 6,
  parameter int RUN_SHORT = 3,
  parameter int RUN_LONG  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_n,
  input  logic                idle_n,
  input  logic                algo3,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_bit,
  output logic                out_valid,
  output logic signed [W-1:0] out_sample
);

  localparam int SW = $clog2(STEP_MAX + 1);

  logic          accept, clr, eff_bit, run;
  logic [SW-1:0] step_q, step_d;

  assign in_ready = pwr_n;
  assign accept   = in_valid & pwr_n;
  assign clr      = ~pwr_n;

  cvsd_bit_select #(
    .RUN_SHORT(RUN_SHORT), .RUN_LONG(RUN_LONG)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .clr(clr), .accept(accept), .in_bit(in_bit),
    .idle_n(idle_n), .algo3(algo3), .eff_bit(eff_bit), .run(run)
  );

  cvsd_step_adapt #(
    .SW(SW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
    .STEP_INC(STEP_INC), .DECAY_SH(DECAY_SH)
  ) u_step (
    .clk(clk), .rst_n(rst_n), .clr(clr), .accept(accept), .run(run),
    .step_q(step_q), .step_d(step_d)
  );

  cvsd_leaky_integ #(
    .W(W), .SW(SW), .LEAK_SH(LEAK_SH)
  ) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(clr), .accept(accept), .bit_in(eff_bit),
    .step(step_d), .integ_q(out_sample)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= accept;
  end

endmodule

// File: rtl/cvsd_decoder_chk.sv
module cvsd_decoder_chk #(
  parameter int W        = 16,
  parameter int SW       = 13,
  parameter int STEP_MIN = 16,
  parameter int STEP_MAX = 4096
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pwr_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic signed [W-1:0] out_sample,
  input logic [SW-1:0]       step
);

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R3

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid); // R3

  AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && !(in_valid && in_ready)) |=> $stable(out_sample)); // R3

  AST_POWERSAVE_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> (out_sample == '0 && !out_valid)); // R1

  AST_POWERSAVE_NO_INTAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |-> !in_ready); // R2

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (step >= SW'(STEP_MIN)) && (step <= SW'(STEP_MAX))); // R5

endmodule

bind cvsd_decoder cvsd_decoder_chk #(
  .W(W), .SW(SW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_sample(out_sample),
  .step(step_q)
);

// File: tb/cvsd_decoder_test.sv
module cvsd_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pwr_n = 1'b1, idle_n = 1'b1, algo3 = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0;
  logic in_ready, out_valid;
  logic signed [15:0] out_sample;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvsd_decoder uut (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .idle_n(idle_n), .algo3(algo3),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  int checks = 0, errors = 0;
  int exp_q[$];
  int last_exp = 0;
  bit done = 1'b0;
  bit track = 1'b0;
  int peak = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model written from R4..R7
  int m_step = 16, m_integ = 0;
  bit [3:0] m_hist = '0;
  bit m_phase = 1'b1;

  function automatic void model_reset();
    m_step = 16; m_integ = 0; m_hist = '0; m_phase = 1'b1;
  endfunction

  function automatic int model_bit(bit b);
    bit eff, run;
    eff = idle_n ? b : m_phase;
    if (!idle_n) m_phase = ~m_phase;
    m_hist = {m_hist[2:0], eff};
    run = algo3 ? (m_hist[2:0] == 3'b000 || m_hist[2:0] == 3'b111)
                : (m_hist == 4'h0 || m_hist == 4'hF);
    if (run) m_step = (m_step + 256 > 4096) ? 4096 : m_step + 256;
    else begin
      m_step = m_step - (m_step >> 5);
      if (m_step < 16) m_step = 16;
    end
    m_integ = m_integ - (m_integ >>> 6) + (eff ? m_step : -m_step);
    if (m_integ > 32767) m_integ = 32767;
    if (m_integ < -32768) m_integ = -32768;
    return m_integ;
  endfunction

  function automatic bit next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: predict, queue, present for one accepting edge
  task automatic send_bit(bit b);
    exp_q.push_back(model_bit(b));
    @(posedge clk); #1;
    in_valid = 1'b1; in_bit = b;
    @(posedge clk); #1;
    in_valid = 1'b0; in_bit = ~b;
  endtask

  task automatic send_pattern(string p);
    for (int i = 0; i < p.len(); i++) send_bit(p[i] == "1");
  endtask

  task automatic powersave();
    @(posedge clk); #1;
    pwr_n = 1'b0; in_valid = 1'b1; in_bit = 1'b1;   // R2: offered bits must be ignored
    @(posedge clk); #1;
    model_reset(); last_exp = 0;
    @(negedge clk);
    check("R1 powersave sample", out_sample, 0);
    check("R1 powersave valid", out_valid, 0);
    check("R2 ready low in powersave", in_ready, 0);
    @(posedge clk); #1;
    pwr_n = 1'b1; in_valid = 1'b0; in_bit = 1'b0;
  endtask

  // monitor: scoreboard pop on each valid pulse, hold check otherwise
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check("R3 valid with nothing queued", 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check("R6 sample vs model", out_sample, e);
          last_exp = e;
          if (track) begin
            int a;
            a = (out_sample < 0) ? -int'(out_sample) : int'(out_sample);
            if (a > peak) peak = a;
          end
        end
      end else if (pwr_n) begin
        check("R3 sample held", out_sample, last_exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    int peak_lo, peak_hi;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset sample", out_sample, 0);
    check("R1 reset valid", out_valid, 0);
    check("R2 ready when powered", in_ready, 1);

    // R4 three-bit runs: 1,1,1 from cleared history -> 16, 32, 304
    algo3 = 1'b1;
    send_bit(1'b1); @(negedge clk); check("R4 3-bit first", out_sample, 16);
    send_bit(1'b1); @(negedge clk); check("R4 3-bit second", out_sample, 32);
    send_bit(1'b1); @(negedge clk); check("R4 3-bit run", out_sample, 304);

    // R10 / R2: powersave with offered bits, then four-bit runs: 16, 32, 48, 320
    powersave();
    algo3 = 1'b0;
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    @(negedge clk); check("R4 4-bit no run at three", out_sample, 48);
    send_bit(1'b1); @(negedge clk); check("R4 4-bit run", out_sample, 320);

    // R5/R6 random streams under each run length
    for (int i = 0; i < 60; i++) send_bit(next_rand());
    algo3 = 1'b1;
    for (int i = 0; i < 60; i++) send_bit(next_rand());

    // R8: run length flips between bits
    for (int i = 0; i < 60; i++) begin
      algo3 = next_rand();
      send_bit(next_rand());
    end

    // R6 saturation at both rails
    algo3 = 1'b1;
    for (int i = 0; i < 80; i++) send_bit(1'b1);
    @(negedge clk); check("R6 positive rail", out_sample, 32767);
    for (int i = 0; i < 120; i++) send_bit(1'b0);
    @(negedge clk); check("R6 negative rail", out_sample, -32768);

    // R7: idle injection ignores in_bit and settles near mid-scale
    idle_n = 1'b0;
    for (int i = 0; i < 1000; i++) send_bit(next_rand());
    @(negedge clk);
    check("R7 idle settles", (out_sample <= 32 && out_sample >= -32) ? 1 : 0, 1);
    idle_n = 1'b1;

    // R9: run density sets amplitude
    powersave();
    algo3 = 1'b1;
    peak = 0; track = 1'b1;
    for (int i = 0; i < 40; i++) send_pattern("110");
    track = 1'b0; peak_lo = peak;
    powersave();
    peak = 0; track = 1'b1;
    for (int i = 0; i < 3; i++) send_pattern("1111110110101010000100000010010101011110");
    track = 1'b0; peak_hi = peak;
    check("R9 dense runs louder", (peak_hi > 2 * peak_lo) ? 1 : 0, 1);

    // R10: restart after powersave matches reset
    powersave();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    @(negedge clk); check("R10 restart run", out_sample, 304);

    repeat (4) @(posedge clk);
    check("R3 all results drained", exp_q.size(), 0);
    finish_sim();
  end

endmodule